// File: doc/BRIEF.md
# Control-Endpoint OUT Buffer Write Gate

This block decides, cycle by cycle, whether a device protocol engine may write received bytes into the OUT buffer of the control endpoint. A one-bit gate opens when a SETUP token arrives, so the eight command bytes can land. It closes by itself the moment the command is complete, so that no later packet can overwrite the command before firmware has read it. Each stage after that needs an explicit reopen from firmware. For an OUT data stage, firmware opens the gate. For an IN data stage, it leaves the gate shut.

Three sticky events are kept. The first says a command is waiting for firmware. The second says the host sent a status-stage OUT while the gate was shut. Such an OUT is refused so the host retries it, and it tells firmware that the data stage is over. The third says the gate was closed by hardware, which is how firmware detects a change of transfer direction. Each event has its own interrupt enable, and the interrupt line is the OR of the enabled events.

A small CPU port reads the gate and stage, opens the gate, clears events with write-one-to-clear, and sets the enables. A system reset and a function-level soft reset both return everything to idle.

Top module: `ep0_out_gate`

## Requirements
- R1: After `rstN` low, or one cycle with `swReset` high, the gate is 0, the stage is idle, and the event flags, enables and `irq` are all 0. A soft reset has priority over every other input in the same cycle.
- R2: A `setupTok` cycle makes the gate 1 and the stage SETUP (code 1) at the next clock edge. This holds from any stage, including a restart while a command is pending.
- R3: A `setupEnd` strobe in stage SETUP makes the gate 0 and the stage CMD (code 2) at the next edge. It also sets the command flag (bit 0) and the gate-closed flag (bit 2).
- R4: `fifoWrEn` equals `rxWrStb` in the same cycle while the gate is 1, and is 0 while the gate is 0.
- R5: A CPU write to address 0 with data bit 0 set opens the gate at the next edge. A write to address 0 with bit 0 clear leaves the gate unchanged.
- R6: `outTok` while the gate is 0 drives `outNak` high in the same cycle. If the stage is CMD, it also sets the status-OUT flag (bit 1) at the next edge. An `outTok` while the gate is 1 is not refused, does not set that flag, and is accepted as a buffer write.
- R7: A CPU write to address 1 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R8: `irq` is 1 exactly when some flag bit and the enable bit at the same position (address 2, bits 2:0) are both 1.
- R9: In one cycle, a hardware event beats a CPU write. A gate closure by `setupEnd` wins over a CPU open, and a flag set wins over its write-one-to-clear.
- R10: Register reads are as follows. Address 0 gives the gate in bit 0 and the stage in bits 2:1 (0 idle, 1 SETUP, 2 CMD). Address 1 gives the flags. Address 2 gives the enables. Address 3 and all unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | System reset, active low, asynchronous |
| swReset | input | 1 | Function-level soft reset, synchronous |
| setupTok | input | 1 | SETUP token to the control endpoint seen |
| setupEnd | input | 1 | Command bytes of the SETUP packet fully received |
| outTok | input | 1 | OUT token to the control endpoint seen |
| rxWrStb | input | 1 | Engine requests a byte write into the OUT buffer |
| fifoWrEn | output | 1 | Gated byte write into the OUT buffer |
| outNak | output | 1 | Current OUT transaction is refused |
| cpuWe | input | 1 | CPU register write strobe |
| cpuAddr | input | 2 | CPU register address |
| cpuWdata | input | CPU_W | CPU write data |
| cpuRdata | output | CPU_W | CPU read data, combinational on `cpuAddr` |
| irq | output | 1 | Abnormal-completion interrupt request |

## Verification
The assertions check on every cycle that a SETUP token opens the gate and restarts the stage. They also check that the gate is always open during stage SETUP, that command completion closes the gate and posts the command flag, that a status-OUT event is captured, and that a soft reset clears all state. Only the bench scenarios can show the register map, the write-one-to-clear masking, and the interrupt OR across every combination of flags and enables. The same holds for the same-cycle contests between hardware events and CPU writes, and for the host's retried status OUT being accepted once firmware reopens the gate.

// File: rtl/ep0_gate_pkg.sv
package ep0_gate_pkg;

  localparam int NFLAG     = 3;
  localparam int FLAG_CMD  = 0;
  localparam int FLAG_STAT = 1;
  localparam int FLAG_FELL = 2;

  typedef enum logic [1:0] {
    STG_IDLE  = 2'd0,
    STG_SETUP = 2'd1,
    STG_CMD   = 2'd2
  } stage_e;

  // Strobes from the stage control into the datapath.
  typedef struct packed {
    logic             clrAll;
    logic             setGate;
    logic             clrGate;
    logic [NFLAG-1:0] setFlag;
  } gateStb_t;

endpackage

// File: rtl/ep0_gate_ctrl.sv
module ep0_gate_ctrl
  import ep0_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     swReset,
  input  logic     setupTok,
  input  logic     setupEnd,
  input  logic     outTok,
  input  logic     gateIn,
  output stage_e   stage,
  output gateStb_t stb
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  stage <= STG_IDLE;
    else if (swReset)                           stage <= STG_IDLE;
    else if (setupTok)                          stage <= STG_SETUP;
    else if (setupEnd && stage == STG_SETUP)    stage <= STG_CMD;
  end

  // Soft reset masks every hardware event; a new SETUP masks the rest.
  always_comb begin
    stb        = '0;
    stb.clrAll = swReset;
    if (!swReset) begin
      if (setupTok) begin
        stb.setGate = 1'b1;
      end else if (stage == STG_SETUP && setupEnd) begin
        stb.clrGate            = 1'b1;
        stb.setFlag[FLAG_CMD]  = 1'b1;
        stb.setFlag[FLAG_FELL] = 1'b1;
      end else if (stage == STG_CMD && outTok && !gateIn) begin
        stb.setFlag[FLAG_STAT] = 1'b1;
      end
    end
  end

  // R2: a SETUP token always restarts stage tracking
  a_r2_setup_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (setupTok && !swReset) |=> (stage == STG_SETUP));

  // R2: command capture never runs with the gate shut
  a_r2_open_during_setup: assert property (@(posedge clk) disable iff (!rstN)
    (stage == STG_SETUP) |-> gateIn);

  // R9: open and close never requested together
  a_r9_single_gate_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setGate, stb.clrGate}));

endmodule

// File: rtl/ep0_gate_dp.sv
module ep0_gate_dp
  import ep0_gate_pkg::*;
#(
  parameter int CPU_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStb_t          stb,
  input  stage_e            stage,
  input  logic              rxWrStb,
  input  logic              outTok,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [CPU_W-1:0]  cpuWdata,
  output logic [CPU_W-1:0]  cpuRdata,
  output logic              gate,
  output logic              fifoWrEn,
  output logic              outNak,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(2);

  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] en;
  logic             fwOpen;
  logic             flagWr;
  logic             unusedBits;

  assign fwOpen     = cpuWe && cpuAddr == A_CTRL && cpuWdata[0];
  assign flagWr     = cpuWe && cpuAddr == A_FLAG;
  assign unusedBits = ^cpuWdata[CPU_W-1:NFLAG];

  // Gate: soft reset, then hardware events, then firmware.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            gate <= 1'b0;
    else if (stb.clrAll)  gate <= 1'b0;
    else if (stb.setGate) gate <= 1'b1;
    else if (stb.clrGate) gate <= 1'b0;
    else if (fwOpen)      gate <= 1'b1;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      flags[i] <= 1'b0;
      else if (stb.clrAll)            flags[i] <= 1'b0;
      else if (stb.setFlag[i])        flags[i] <= 1'b1;
      else if (flagWr && cpuWdata[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            en <= '0;
    else if (stb.clrAll)                  en <= '0;
    else if (cpuWe && cpuAddr == A_EN)    en <= cpuWdata[NFLAG-1:0];
  end

  assign fifoWrEn = rxWrStb && gate;
  assign outNak   = outTok && !gate;
  assign irq      = |(flags & en);

  always_comb begin
    cpuRdata = '0;
    case (cpuAddr)
      A_CTRL: begin
        cpuRdata[0]   = gate;
        cpuRdata[2:1] = stage;
      end
      A_FLAG:  cpuRdata[NFLAG-1:0] = flags;
      A_EN:    cpuRdata[NFLAG-1:0] = en;
      default: cpuRdata = '0;
    endcase
  end

  // R2: a SETUP strobe opens the gate regardless of firmware
  a_r2_setup_opens: assert property (@(posedge clk) disable iff (!rstN)
    stb.setGate |=> gate);

  // R3: command completion closes the gate and posts the command
  a_r3_end_closes: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrGate |=> (!gate && flags[FLAG_CMD] && flags[FLAG_FELL]));

  // R6: a refused status OUT is always recorded
  a_r6_stat_captured: assert property (@(posedge clk) disable iff (!rstN)
    stb.setFlag[FLAG_STAT] |=> flags[FLAG_STAT]);

  // R1: soft reset leaves nothing behind
  a_r1_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAll |=> (!gate && flags == '0 && en == '0));

  initial a_r10_width: assert (CPU_W >= NFLAG && CPU_W >= 3);

endmodule

// File: rtl/ep0_out_gate.sv
module ep0_out_gate
  import ep0_gate_pkg::*;
#(
  parameter int CPU_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  logic             setupTok,
  input  logic             setupEnd,
  input  logic             outTok,
  input  logic             rxWrStb,
  output logic             fifoWrEn,
  output logic             outNak,
  input  logic             cpuWe,
  input  logic [1:0]       cpuAddr,
  input  logic [CPU_W-1:0] cpuWdata,
  output logic [CPU_W-1:0] cpuRdata,
  output logic             irq
);

  stage_e   stage;
  gateStb_t stb;
  logic     gate;

  ep0_gate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .swReset  (swReset),
    .setupTok (setupTok),
    .setupEnd (setupEnd),
    .outTok   (outTok),
    .gateIn   (gate),
    .stage    (stage),
    .stb      (stb)
  );

  ep0_gate_dp #(.CPU_W(CPU_W), .ADDR_W(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .stage    (stage),
    .rxWrStb  (rxWrStb),
    .outTok   (outTok),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .cpuRdata (cpuRdata),
    .gate     (gate),
    .fifoWrEn (fifoWrEn),
    .outNak   (outNak),
    .irq      (irq)
  );

endmodule

// File: tb/ep0_out_gate_bench.sv
module ep0_out_gate_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swReset = 1'b0, setupTok = 1'b0, setupEnd = 1'b0, outTok = 1'b0, rxWrStb = 1'b0;
  logic       cpuWe = 1'b0;
  logic [1:0] cpuAddr = 2'd0;
  logic [7:0] cpuWdata = 8'd0;
  logic [7:0] cpuRdata;
  logic       fifoWrEn, outNak, irq;
  int         nChk = 0, nFail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ep0_out_gate #(.CPU_W(8)) u_ep0_out_gate (
    .clk(clk), .rstN(rstN), .swReset(swReset), .setupTok(setupTok),
    .setupEnd(setupEnd), .outTok(outTok), .rxWrStb(rxWrStb),
    .fifoWrEn(fifoWrEn), .outNak(outNak), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // m: bit0 setupTok, bit1 setupEnd, bit2 outTok, bit3 swReset
  task automatic strobe(input logic [3:0] m);
    setupTok = m[0]; setupEnd = m[1]; outTok = m[2]; swReset = m[3];
    tick();
    setupTok = 0; setupEnd = 0; outTok = 0; swReset = 0;
  endtask

  task automatic cpuWr(input logic [1:0] a, input logic [7:0] d);
    cpuWe = 1; cpuAddr = a; cpuWdata = d;
    tick();
    cpuWe = 0; cpuWdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cpuAddr = a;
    #1;
    d = cpuRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // Reset state
    rd(0, v); chk("R1 ctrl after reset", v, 8'd0);
    rd(1, v); chk("R1 flags after reset", v, 8'd0);
    rd(2, v); chk("R1 enables after reset", v, 8'd0);
    rd(3, v); chk("R10 address 3 reads zero", v, 8'd0);
    chk("R1 irq after reset", {7'd0, irq}, 8'd0);
    rxWrStb = 1; #1;
    chk("R4 write blocked after reset", {7'd0, fifoWrEn}, 8'd0);
    rxWrStb = 0;

    // Setup stage
    strobe(4'b0001);
    rd(0, v); chk("R2 gate open, stage SETUP", v, 8'd3);
    rxWrStb = 1; #1;
    chk("R4 write passes while open", {7'd0, fifoWrEn}, 8'd1);
    rxWrStb = 0;
    strobe(4'b0010);
    rd(0, v); chk("R3 gate closed, stage CMD", v, 8'd4);
    rd(1, v); chk("R3 command and closed flags", v, 8'd5);
    rxWrStb = 1; #1;
    chk("R4 write blocked after command", {7'd0, fifoWrEn}, 8'd0);
    rxWrStb = 0;

    // Status OUT while shut
    outTok = 1; #1;
    chk("R6 OUT refused while shut", {7'd0, outNak}, 8'd1);
    tick(); outTok = 0;
    rd(1, v); chk("R6 status flag set", v, 8'd7);

    // Firmware reopen
    cpuWr(0, 8'h00);
    rd(0, v); chk("R5 write of zero ignored", v, 8'd4);
    cpuWr(1, 8'h02);
    rd(1, v); chk("R7 clear only status flag", v, 8'd5);
    cpuWr(0, 8'h01);
    rd(0, v); chk("R5 firmware opens gate", v, 8'd5);
    outTok = 1; rxWrStb = 1; #1;
    chk("R6 retried OUT accepted", {7'd0, outNak}, 8'd0);
    chk("R6 retried OUT written", {7'd0, fifoWrEn}, 8'd1);
    tick(); outTok = 0; rxWrStb = 0;
    rd(1, v); chk("R6 no status flag when open", v, 8'd5);

    // Restart from CMD
    cpuWr(1, 8'h07);
    strobe(4'b0001);
    rd(0, v); chk("R2 restart to SETUP", v, 8'd3);

    // Hardware close beats CPU open
    cpuWe = 1; cpuAddr = 0; cpuWdata = 8'h01;
    strobe(4'b0010);
    cpuWe = 0; cpuWdata = 0;
    rd(0, v); chk("R9 close beats CPU open", v, 8'd4);

    // Flag set beats clear
    cpuWr(1, 8'h07);
    strobe(4'b0001);
    cpuWe = 1; cpuAddr = 1; cpuWdata = 8'h07;
    strobe(4'b0010);
    cpuWe = 0; cpuWdata = 0;
    rd(1, v); chk("R9 set beats clear", v, 8'd5);

    // Soft reset beats SETUP, clears enables
    cpuWr(2, 8'h07);
    chk("R8 irq with enables", {7'd0, irq}, 8'd1);
    strobe(4'b1001);
    rd(0, v); chk("R1 soft reset beats SETUP", v, 8'd0);
    rd(1, v); chk("R1 soft reset clears flags", v, 8'd0);
    rd(2, v); chk("R1 soft reset clears enables", v, 8'd0);

    // OUT in idle: refused but no flag
    outTok = 1; #1;
    chk("R6 OUT refused in idle", {7'd0, outNak}, 8'd1);
    tick(); outTok = 0;
    rd(1, v); chk("R6 no status flag in idle", v, 8'd0);

    // Sweep all flag patterns and enable masks
    for (int p = 0; p < 8; p++) begin
      for (int e = 0; e < 8; e++) begin
        strobe(4'b1000);
        strobe(4'b0001);
        strobe(4'b0010);
        strobe(4'b0100);
        cpuWr(1, 8'(~p & 7));
        cpuWr(2, 8'(e));
        rd(1, v); chk("R7 masked clear", v, 8'(p));
        chk("R8 irq OR of enabled flags", {7'd0, irq}, {7'd0, |(p[2:0] & e[2:0])});
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule